// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor. On each clock where a valid operation is presented, it combines the accumulator value with a second operand and with the carry and half-carry it holds from earlier operations. It then registers the result, a write strobe telling the surrounding datapath whether the accumulator should take that result, and an updated flag byte.

The flag byte holds carry, zero, sign, parity and half-carry (auxiliary carry). Each operation class updates its own subset of these flags. Compare sets every flag but leaves the accumulator alone. Rotates touch only carry. Increment and decrement leave carry alone. Decimal adjust uses both stored carries to correct a packed BCD byte. Opcode decoding, the register file and memory access belong to the surrounding processor.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low and after its release, `flags_q` is 0x02, `result_q` is 0 and `acc_wr_q` is 0. Flag bits are: sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2, carry at bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R2: An operation with `op_valid` high is sampled on a rising edge, and its result, strobe and flags appear on the outputs from that edge on. With `op_valid` low, `result_q` and `flags_q` hold and `acc_wr_q` is 0. Op codes 18 to 31 leave the flags unchanged, set `result_q` to `acc_in` and keep `acc_wr_q` low. The op codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 increment, 9 decrement, 10 complement, 11 set carry, 12 toggle carry, 13 rotate left circular, 14 rotate right circular, 15 rotate left through carry, 16 rotate right through carry, 17 decimal adjust.
- R3: Every operation that updates zero, sign and parity derives them from its 8-bit arithmetic or logic value. Zero is 1 when that value is 0. Sign equals its bit 7. Parity is 1 when it holds an even number of ones.
- R4: Add (0) and add with carry (1) write acc+opnd (+carry for code 1). Carry is the carry out of bit 7, and half-carry is the carry out of bit 3.
- R5: Subtract (2) and subtract with borrow (3) write acc-opnd (-carry for code 3). Carry is 1 on a borrow. Half-carry is 1 when the low nibble of acc is greater than or equal to the low nibble of opnd plus the borrow-in.
- R6: Compare (7) sets all flags exactly as subtract would, sets `result_q` to `acc_in` and keeps `acc_wr_q` low.
- R7: Increment (8) and decrement (9) act on `acc_in` and leave carry unchanged. Increment sets half-carry when the low nibble was 0xF. Decrement sets half-carry when the low nibble was not 0.
- R8: AND, OR and XOR write the bitwise result and clear carry. Half-carry becomes 1 for AND and 0 for OR and XOR.
- R9: Complement (10) writes the bitwise inverse of `acc_in` and leaves all flags unchanged.
- R10: Set carry (11) forces carry to 1, and toggle carry (12) inverts it. Both leave the other flags unchanged, set `result_q` to `acc_in` and keep `acc_wr_q` low.
- R11: Rotate left circular (13) moves bit 7 to bit 0 and to carry. Rotate right circular (14) moves bit 0 to bit 7 and to carry. Only carry changes.
- R12: Rotate left through carry (15) shifts the old carry into bit 0 and bit 7 into carry. Rotate right through carry (16) shifts the old carry into bit 7 and bit 0 into carry. Only carry changes.
- R13: Decimal adjust (17) adds 0x06 when the low nibble exceeds 9 or half-carry is set. It adds 0x60 when carry is set or acc exceeds 0x99. The new carry is 1 when the 0x60 correction applies, and half-carry is the carry out of bit 3 of the low correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (encoding in R2) |
| acc_in | input | DATA_W | Accumulator operand |
| opnd_in | input | DATA_W | Second operand |
| result_q | output | DATA_W | Registered result |
| acc_wr_q | output | 1 | Registered strobe: accumulator takes `result_q` |
| flags_q | output | 8 | Registered flag byte (layout in R1) |

## Verification
Every result, strobe and flag change belongs to the rising edge that samples the operation, so all three are due one cycle after the inputs are applied. The bench drives inputs on the falling edge and advances its own model at the next rising edge. It compares all three outputs on the falling edge that follows, every cycle, before any new input is applied. Idle cycles, unused codes, flag-preserving operations and carry-dependent chains are compared in the same way, so a flag that changes when it should hold is seen at the first cycle it happens.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD = 5'd0,
      OP_ADC = 5'd1,
      OP_SUB = 5'd2,
      OP_SBB = 5'd3,
      OP_AND = 5'd4,
      OP_OR  = 5'd5,
      OP_XOR = 5'd6,
      OP_CMP = 5'd7,
      OP_INC = 5'd8,
      OP_DEC = 5'd9,
      OP_CMA = 5'd10,
      OP_STC = 5'd11,
      OP_CMC = 5'd12,
      OP_RLC = 5'd13,
      OP_RRC = 5'd14,
      OP_RAL = 5'd15,
      OP_RAR = 5'd16,
      OP_DAA = 5'd17
   } alu_op_e;

   // flag set held between operations
   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } flags_t;

   localparam int FLAG_BYTE_W = 8;
   localparam int POS_S  = 7;
   localparam int POS_Z  = 6;
   localparam int POS_AC = 4;
   localparam int POS_P  = 2;
   localparam int POS_CY = 0;
   localparam int POS_ONE = 1;

   function automatic logic [FLAG_BYTE_W-1:0] pack_flags(input flags_t f);
      logic [FLAG_BYTE_W-1:0] v;
      v = '0;
      v[POS_S]   = f.s;
      v[POS_Z]   = f.z;
      v[POS_AC]  = f.ac;
      v[POS_P]   = f.p;
      v[POS_CY]  = f.cy;
      v[POS_ONE] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
// shared adder for add, subtract, compare, increment and decrement
module acc_alu_addsub #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              hcarry
);
   logic [DATA_W-1:0] b_eff;
   logic              c_eff;
   logic [DATA_W:0]   full;
   logic [NIB_W:0]    low;

   initial begin
      assert (NIB_W > 0 && NIB_W < DATA_W)
         else $error("acc_alu_addsub: NIB_W must lie inside DATA_W");
   end

   always_comb begin
      b_eff  = sub ? ~b : b;
      c_eff  = sub ? ~cin : cin;
      full   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
      low    = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
      sum    = full[DATA_W-1:0];
      cout   = sub ? ~full[DATA_W] : full[DATA_W];
      hcarry = low[NIB_W];
   end
endmodule

// File: rtl/acc_alu_bitops.sv
`timescale 1ns/1ps
// bitwise logic and single-bit rotates of the accumulator
module acc_alu_bitops
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cy,
   output logic [DATA_W-1:0] r,
   output logic              cy_out
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      r      = a;
      cy_out = cy;
      unique case (op)
         OP_AND:  r = a & b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_CMA:  r = ~a;
         OP_RLC:  begin r = {a[MSB-1:0], a[MSB]}; cy_out = a[MSB]; end
         OP_RRC:  begin r = {a[0], a[MSB:1]};     cy_out = a[0];   end
         OP_RAL:  begin r = {a[MSB-1:0], cy};     cy_out = a[MSB]; end
         OP_RAR:  begin r = {cy, a[MSB:1]};       cy_out = a[0];   end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_decadj.sv
`timescale 1ns/1ps
// packed-BCD correction after a binary add
module acc_alu_decadj #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic              cy,
   input  logic              ac,
   output logic [DATA_W-1:0] r,
   output logic              cy_out,
   output logic              ac_out
);
   localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
   localparam logic [DATA_W-1:0] BYTE_MAX  = DATA_W'(8'h99);
   localparam logic [DATA_W-1:0] FIX_LO    = DATA_W'(8'h06);
   localparam logic [DATA_W-1:0] FIX_HI    = DATA_W'(8'h60);

   logic           lo_fix;
   logic           hi_fix;
   logic [NIB_W:0] lo_sum;

   initial begin
      assert (DATA_W == 2 * NIB_W)
         else $error("acc_alu_decadj: two digits per word expected");
   end

   always_comb begin
      lo_fix = (a[NIB_W-1:0] > DIGIT_MAX) | ac;
      hi_fix = cy | (a > BYTE_MAX);
      lo_sum = {1'b0, a[NIB_W-1:0]} + (lo_fix ? (NIB_W+1)'(6) : '0);
      r      = a + (lo_fix ? FIX_LO : '0) + (hi_fix ? FIX_HI : '0);
      cy_out = hi_fix;
      ac_out = lo_sum[NIB_W];
   end
endmodule

// File: rtl/acc_alu_parity.sv
`timescale 1ns/1ps
// balanced XOR tree; even = 1 when the count of ones is even
module acc_alu_parity #(
   parameter int W = 8
) (
   input  logic [W-1:0] d,
   output logic         even
);
   localparam int NODES = 2 * W - 1;
   logic [NODES-1:0] node;

   initial begin
      assert (W >= 2 && (W & (W - 1)) == 0)
         else $error("acc_alu_parity: W must be a power of two");
   end

   for (genvar i = 0; i < W; i++) begin : g_leaf
      assign node[W-1+i] = d[i];
   end
   for (genvar j = 0; j < W - 1; j++) begin : g_inner
      assign node[j] = node[2*j+1] ^ node[2*j+2];
   end

   assign even = ~node[0];
endmodule

// File: rtl/acc_alu_flagreg.sv
`timescale 1ns/1ps
// per-flag enabled storage, packed into the flag byte
module acc_alu_flagreg
   import acc_alu_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  flags_t                 upd,
   input  flags_t                 nxt,
   output flags_t                 cur,
   output logic [FLAG_BYTE_W-1:0] flags_q
);
   localparam int NFLAGS = $bits(flags_t);

   logic [NFLAGS-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         for (int i = 0; i < NFLAGS; i++) begin
            if (en && upd[i]) st[i] <= nxt[i];
         end
      end
   end

   assign cur     = flags_t'(st);
   assign flags_q = pack_flags(cur);

   // zero and sign come from one value and are written together
   assert_zero_sign_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(flags_q[POS_Z] && flags_q[POS_S]));
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic [4:0]             op_code,
   input  logic [DATA_W-1:0]      acc_in,
   input  logic [DATA_W-1:0]      opnd_in,
   output logic [DATA_W-1:0]      result_q,
   output logic                   acc_wr_q,
   output logic [FLAG_BYTE_W-1:0] flags_q
);
   localparam int MSB = DATA_W - 1;
   localparam flags_t UPD_ALL  = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b1};
   localparam flags_t UPD_NOCY = '{s: 1'b1, z: 1'b1, ac: 1'b1, p: 1'b1, cy: 1'b0};
   localparam flags_t UPD_CY   = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b1};
   localparam flags_t UPD_NONE = '0;

   initial begin
      assert (DATA_W == 8)
         else $error("acc_alu: the flag byte is defined for 8-bit data");
      assert (NIB_W * 2 == DATA_W)
         else $error("acc_alu: NIB_W must be half of DATA_W");
   end

   alu_op_e           op;
   flags_t            cur;
   flags_t            upd;
   flags_t            nf;
   logic [DATA_W-1:0] as_b;
   logic              as_sub;
   logic              as_cin;
   logic [DATA_W-1:0] as_sum;
   logic              as_cout;
   logic              as_hc;
   logic [DATA_W-1:0] bo_r;
   logic              bo_cy;
   logic [DATA_W-1:0] da_r;
   logic              da_cy;
   logic              da_ac;
   logic [DATA_W-1:0] fsrc;
   logic              fsrc_even;
   logic [DATA_W-1:0] nxt_res;
   logic              nxt_wr;

   assign op = alu_op_e'(op_code);

   acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
      .a(acc_in), .b(as_b), .sub(as_sub), .cin(as_cin),
      .sum(as_sum), .cout(as_cout), .hcarry(as_hc)
   );

   acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op(op), .a(acc_in), .b(opnd_in), .cy(cur.cy),
      .r(bo_r), .cy_out(bo_cy)
   );

   acc_alu_decadj #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_decadj (
      .a(acc_in), .cy(cur.cy), .ac(cur.ac),
      .r(da_r), .cy_out(da_cy), .ac_out(da_ac)
   );

   acc_alu_parity #(.W(DATA_W)) u_parity (
      .d(fsrc), .even(fsrc_even)
   );

   // adder operand selection
   always_comb begin
      as_b   = opnd_in;
      as_sub = 1'b0;
      as_cin = 1'b0;
      unique case (op)
         OP_ADC:  as_cin = cur.cy;
         OP_SUB,
         OP_CMP:  as_sub = 1'b1;
         OP_SBB:  begin as_sub = 1'b1; as_cin = cur.cy; end
         OP_INC:  begin as_b = '0; as_cin = 1'b1; end
         OP_DEC:  begin as_b = '0; as_sub = 1'b1; as_cin = 1'b1; end
         default: ;
      endcase
   end

   // per-class result, strobe and flag update
   always_comb begin
      nxt_res = acc_in;
      nxt_wr  = 1'b0;
      fsrc    = acc_in;
      upd     = UPD_NONE;
      nf      = cur;
      unique case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            nxt_res = as_sum;
            nxt_wr  = 1'b1;
            fsrc    = as_sum;
            upd     = UPD_ALL;
            nf.cy   = as_cout;
            nf.ac   = as_hc;
         end
         OP_CMP: begin
            fsrc  = as_sum;
            upd   = UPD_ALL;
            nf.cy = as_cout;
            nf.ac = as_hc;
         end
         OP_INC, OP_DEC: begin
            nxt_res = as_sum;
            nxt_wr  = 1'b1;
            fsrc    = as_sum;
            upd     = UPD_NOCY;
            nf.ac   = as_hc;
         end
         OP_AND, OP_OR, OP_XOR: begin
            nxt_res = bo_r;
            nxt_wr  = 1'b1;
            fsrc    = bo_r;
            upd     = UPD_ALL;
            nf.cy   = 1'b0;
            nf.ac   = (op == OP_AND);
         end
         OP_CMA: begin
            nxt_res = bo_r;
            nxt_wr  = 1'b1;
         end
         OP_STC: begin
            upd   = UPD_CY;
            nf.cy = 1'b1;
         end
         OP_CMC: begin
            upd   = UPD_CY;
            nf.cy = ~cur.cy;
         end
         OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
            nxt_res = bo_r;
            nxt_wr  = 1'b1;
            upd     = UPD_CY;
            nf.cy   = bo_cy;
         end
         OP_DAA: begin
            nxt_res = da_r;
            nxt_wr  = 1'b1;
            fsrc    = da_r;
            upd     = UPD_ALL;
            nf.cy   = da_cy;
            nf.ac   = da_ac;
         end
         default: ;
      endcase
      nf.z = (fsrc == '0);
      nf.s = fsrc[MSB];
      nf.p = fsrc_even;
   end

   acc_alu_flagreg u_flagreg (
      .clk(clk), .rst_n(rst_n), .en(op_valid),
      .upd(upd), .nxt(nf), .cur(cur), .flags_q(flags_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         acc_wr_q <= 1'b0;
      end else begin
         acc_wr_q <= op_valid & nxt_wr;
         if (op_valid) result_q <= nxt_res;
      end
   end

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(flags_q) && $stable(result_q) && !acc_wr_q));

   assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd7) |=> (!acc_wr_q && result_q == $past(acc_in)));

   assert_incdec_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 5'd8 || op_code == 5'd9))
         |=> flags_q[POS_CY] == $past(flags_q[POS_CY]));

   assert_cma_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd10) |=> ($stable(flags_q) && acc_wr_q));

   assert_stc_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd11) |=> (flags_q[POS_CY] && !acc_wr_q));

   assert_rotate_cy_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code >= 5'd13 && op_code <= 5'd16)
         |=> flags_q[7:1] == $past(flags_q[7:1]));

   assert_daa_keeps_carry_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 5'd17 && flags_q[POS_CY]) |=> flags_q[POS_CY]);
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [7:0] acc_in = '0;
   logic [7:0] opnd_in = '0;
   logic [7:0] result_q;
   logic       acc_wr_q;
   logic [7:0] flags_q;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // reference model state
   logic [7:0] m_res = '0;
   logic       m_wr = 1'b0;
   logic [7:0] m_fl = 8'h02;

   always #10 clk = ~clk;

   acc_alu u_acc_alu (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .acc_in(acc_in), .opnd_in(opnd_in), .result_q(result_q),
      .acc_wr_q(acc_wr_q), .flags_q(flags_q)
   );

   function automatic string req_of(input logic v, input logic [4:0] op);
      if (!v) return "R2";
      case (op)
         5'd0, 5'd1:          return "R4";
         5'd2, 5'd3:          return "R5";
         5'd4, 5'd5, 5'd6:    return "R8";
         5'd7:                return "R6";
         5'd8, 5'd9:          return "R7";
         5'd10:               return "R9";
         5'd11, 5'd12:        return "R10";
         5'd13, 5'd14:        return "R11";
         5'd15, 5'd16:        return "R12";
         5'd17:               return "R13";
         default:             return "R2";
      endcase
   endfunction

   function automatic bit even_ones(input int v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += (v >> i) & 1;
      return (n % 2) == 0;
   endfunction

   task automatic model_update(input logic v, input logic [4:0] op,
                               input logic [7:0] a8, input logic [7:0] b8);
      int a = int'(a8);
      int b = int'(b8);
      int cy = int'(m_fl[0]);
      int ac = int'(m_fl[4]);
      int s = int'(m_fl[7]);
      int z = int'(m_fl[6]);
      int p = int'(m_fl[2]);
      int r = a;
      int fv = 0;
      int c;
      bit szp = 1'b0;
      bit wr = 1'b0;
      if (!v) begin
         m_wr = 1'b0;
         return;
      end
      case (op)
         5'd0, 5'd1: begin
            c = (op == 5'd1) ? cy : 0;
            fv = a + b + c;
            ac = ((a & 15) + (b & 15) + c) > 15;
            cy = fv > 255;
            fv = fv & 255; r = fv; wr = 1; szp = 1;
         end
         5'd2, 5'd3, 5'd7: begin
            c = (op == 5'd3) ? cy : 0;
            ac = (a & 15) >= ((b & 15) + c);
            cy = a < (b + c);
            fv = (a - b - c) & 255; szp = 1;
            if (op != 5'd7) begin r = fv; wr = 1; end
         end
         5'd8: begin
            ac = (a & 15) == 15; fv = (a + 1) & 255; r = fv; wr = 1; szp = 1;
         end
         5'd9: begin
            ac = (a & 15) != 0; fv = (a - 1) & 255; r = fv; wr = 1; szp = 1;
         end
         5'd4, 5'd5, 5'd6: begin
            fv = (op == 5'd4) ? (a & b) : (op == 5'd5) ? (a | b) : (a ^ b);
            cy = 0; ac = (op == 5'd4); r = fv; wr = 1; szp = 1;
         end
         5'd10: begin r = (~a) & 255; wr = 1; end
         5'd11: cy = 1;
         5'd12: cy = 1 - cy;
         5'd13: begin r = ((a << 1) | (a >> 7)) & 255; cy = (a >> 7) & 1; wr = 1; end
         5'd14: begin r = ((a >> 1) | ((a & 1) << 7)) & 255; cy = a & 1; wr = 1; end
         5'd15: begin r = ((a << 1) | cy) & 255; cy = (a >> 7) & 1; wr = 1; end
         5'd16: begin r = ((a >> 1) | (cy << 7)) & 255; cy = a & 1; wr = 1; end
         5'd17: begin
            int lo;
            int hi;
            lo = ((a & 15) > 9) || (ac != 0);
            hi = (cy != 0) || (a > 153);
            ac = ((a & 15) + (lo ? 6 : 0)) > 15;
            cy = hi;
            fv = (a + (lo ? 6 : 0) + (hi ? 96 : 0)) & 255;
            r = fv; wr = 1; szp = 1;
         end
         default: ;
      endcase
      if (szp) begin
         z = (fv == 0);
         s = (fv >> 7) & 1;
         p = even_ones(fv);
      end
      m_res = 8'(r);
      m_wr  = wr;
      m_fl  = {s[0], z[0], 1'b0, ac[0], 1'b0, p[0], 1'b1, cy[0]};
   endtask

   task automatic compare(input string rq);
      checks++;
      if (result_q !== m_res) begin
         fails++;
         $display("FAIL %s result actual=%02h expected=%02h", rq, result_q, m_res);
      end
      checks++;
      if (acc_wr_q !== m_wr) begin
         fails++;
         $display("FAIL %s strobe actual=%0b expected=%0b", rq, acc_wr_q, m_wr);
      end
      checks++;
      if (flags_q !== m_fl) begin
         fails++;
         $display("FAIL %s flags actual=%02h expected=%02h", rq, flags_q, m_fl);
      end
   endtask

   // inputs change on the falling edge; outputs are compared one falling edge later
   task automatic step(input logic v, input logic [4:0] op,
                       input logic [7:0] a, input logic [7:0] b);
      op_valid = v; op_code = op; acc_in = a; opnd_in = b;
      @(posedge clk);
      #1 model_update(v, op, a, b);
      @(negedge clk);
      compare(req_of(v, op));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");                       // state during reset
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");                       // state after release, idle
      // R4: add with carry out and half-carry
      step(1, 5'd0, 8'h9C, 8'h78);
      step(1, 5'd1, 8'h0F, 8'h00);
      step(1, 5'd0, 8'h80, 8'h80);
      // R5: subtract with borrow chain and R6 compare
      step(1, 5'd2, 8'h10, 8'h21);
      step(1, 5'd3, 8'h50, 8'h10);
      step(1, 5'd7, 8'h42, 8'h42);
      step(1, 5'd7, 8'h05, 8'h07);
      // R7: increment and decrement keep carry
      step(1, 5'd8, 8'hFF, 8'h00);
      step(1, 5'd9, 8'h00, 8'h00);
      step(1, 5'd9, 8'h10, 8'h00);
      // R8 logic ops
      step(1, 5'd4, 8'hF0, 8'h3C);
      step(1, 5'd5, 8'h00, 8'h00);
      step(1, 5'd6, 8'hAA, 8'h55);
      // R9 complement, R10 carry control
      step(1, 5'd10, 8'h5A, 8'h00);
      step(1, 5'd11, 8'h33, 8'h00);
      step(1, 5'd12, 8'h33, 8'h00);
      step(1, 5'd12, 8'h33, 8'h00);
      // R11 and R12 rotates
      step(1, 5'd13, 8'h81, 8'h00);
      step(1, 5'd14, 8'h01, 8'h00);
      step(1, 5'd11, 8'h00, 8'h00);
      step(1, 5'd15, 8'h40, 8'h00);
      step(1, 5'd16, 8'h02, 8'h00);
      // R13 decimal adjust: both corrections, carry-only, half-carry-only
      step(1, 5'd0, 8'h00, 8'h00);
      step(1, 5'd17, 8'h9B, 8'h00);
      step(1, 5'd0, 8'h09, 8'h09);
      step(1, 5'd17, 8'h12, 8'h00);
      step(1, 5'd11, 8'h00, 8'h00);
      step(1, 5'd17, 8'h23, 8'h00);
      // R2 idle and unused codes
      step(0, 5'd0, 8'hFF, 8'hFF);
      step(1, 5'd20, 8'h77, 8'h11);
      step(1, 5'd31, 8'h00, 8'h01);
      for (int i = 0; i < 600; i++) begin
         step(($urandom_range(0, 7) != 0), 5'($urandom_range(0, 23)),
              8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule